// File: doc/BRIEF.md
# SAR ADC Register Controller

This block is the digital front end of a successive-approximation analog-to-digital converter with up to eight multiplexed inputs. Software reaches it through four 32-bit registers on a simple single-cycle bus: a result register, a status register, a control register and a start-delay register. The block drives the converter's power enable and its input select, and it presents a trial code to the external DAC. It samples a comparator bit that reports whether the selected input lies at or above that trial level.

Software starts a conversion by writing the control register with the power bit set and a channel number. The block powers the converter and waits the programmed number of clock cycles for it to settle. It then runs a binary search that resolves one result bit per clock cycle, starting from the MSB. At the end it stores the code, sets the interrupt status and, if enabled, raises the interrupt line. Writing control with the power bit clear shuts the converter down, cancels any conversion in progress and clears the interrupt.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the result, status and control registers read 0, the delay register reads 8, and `pwr_en_o`, `irq_o` and `dac_code_o` are 0.
- R2: Register index `addr_i[3:2]` selects the register: 0 is the result, 1 is status, 2 is control and 3 is delay. The result register returns the RES_BITS-bit code in the low bits, and all bits above it read 0. Status bit 0 is busy. Control bits [2:0] hold the channel, bit 3 is power, bit 5 is the interrupt enable and bit 6 is the read-only interrupt status.
- R3: A control write with bit 3 set while idle starts a conversion. From the next cycle on, `pwr_en_o` is 1, `chan_sel_o` equals bits [2:0] of the write, and busy is 1.
- R4: With delay value D latched at the start, busy stays set for exactly D + RES_BITS cycles. `dac_code_o` is 0 whenever no search step is active.
- R5: The search makes one trial per cycle, from the MSB down. It keeps a bit when `cmp_i` is 1, so against an ideal comparator the result equals the input code. This includes the codes 0 and all ones.
- R6: At the end of a conversion the result register is loaded, control bit 6 becomes 1, busy clears, and power stays on.
- R7: `irq_o` is 1 exactly when interrupt status and interrupt enable are both 1.
- R8: While busy, a control write with bit 3 set is ignored. The channel, the enable and the running conversion are unaffected.
- R9: A control write with bit 3 clear takes effect on the next cycle. It turns power off, clears busy, interrupt status and `irq_o`, and aborts any conversion. The result register keeps its previous value.
- R10: The delay register stores only write bits [5:0]. Its upper bits read 0.
- R11: With a delay of 0, the first trial is made in the cycle right after the start write, and busy lasts exactly RES_BITS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter and bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (4) | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| cmp_i | input | 1 | Comparator: input is at or above the trial level |
| pwr_en_o | output | 1 | Converter power enable |
| chan_sel_o | output | CHAN_W (3) | Analog input select |
| dac_code_o | output | RES_BITS (10) | Trial level for the DAC |
| irq_o | output | 1 | End-of-conversion interrupt |

## Verification
The hardest situations to reach are control writes that arrive while a conversion is running. One is a power-down that lands partway through the bit search. The other is a restart attempt that lands during the settle delay. Both must hit a particular cycle inside the conversion. The bench keeps a free-running cycle count, so it can place each write a known number of cycles after the start. It then checks the duration of busy, the retained result and the outputs. A clean conversion after an abort shows that the search state is reloaded and does not carry over.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int unsigned BUS_W = 32;

  localparam int unsigned REG_RESULT = 0;
  localparam int unsigned REG_STATUS = 1;
  localparam int unsigned REG_CTRL   = 2;
  localparam int unsigned REG_DELAY  = 3;

  localparam int unsigned CTRL_PWR_BIT = 3;
  localparam int unsigned CTRL_IE_BIT  = 5;
  localparam int unsigned CTRL_IRQ_BIT = 6;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_WAIT,
    SEQ_CONV
  } seq_state_e;
endpackage

// File: rtl/sar_adc_search.sv
module sar_adc_search #(
  parameter int unsigned RES_BITS = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                step_i,
  input  logic                conv_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] trial_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                last_o
);
  localparam logic [RES_BITS-1:0] MSB_ONEHOT = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] code_q;
  logic [RES_BITS-1:0] probe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      probe_q <= '0;
    end else if (load_i) begin
      code_q  <= '0;
      probe_q <= MSB_ONEHOT;
    end else if (step_i) begin
      if (cmp_i) code_q <= code_q | probe_q;
      probe_q <= probe_q >> 1;
    end
  end

  assign trial_o  = conv_i ? (code_q | probe_q) : '0;
  assign result_o = cmp_i ? (code_q | probe_q) : code_q;
  assign last_o   = probe_q[0];
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq import sar_adc_pkg::*; #(
  parameter int unsigned DLY_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             last_i,
  output logic             busy_o,
  output logic             conv_o,
  output logic             load_o,
  output logic             step_o,
  output logic             done_o
);
  seq_state_e       state_q;
  logic [DLY_W-1:0] wait_q;

  assign busy_o = (state_q != SEQ_IDLE);
  assign conv_o = (state_q == SEQ_CONV);
  assign step_o = conv_o && !abort_i;
  assign done_o = step_o && last_i;
  assign load_o = (start_i && (dly_i == '0)) ||
                  (state_q == SEQ_WAIT && wait_q == DLY_W'(1) && !abort_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      wait_q  <= '0;
    end else if (abort_i) begin
      state_q <= SEQ_IDLE;
      wait_q  <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= (dly_i == '0) ? SEQ_CONV : SEQ_WAIT;
          wait_q  <= dly_i;
        end
        SEQ_WAIT: begin
          wait_q <= wait_q - DLY_W'(1);
          if (wait_q == DLY_W'(1)) state_q <= SEQ_CONV;
        end
        SEQ_CONV: if (last_i) state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs import sar_adc_pkg::*; #(
  parameter int unsigned RES_BITS = 10,
  parameter int unsigned CHAN_W   = 3,
  parameter int unsigned DLY_W    = 6,
  parameter int unsigned DLY_RST  = 8,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  input  logic                busy_i,
  input  logic                done_i,
  input  logic [RES_BITS-1:0] result_i,
  output logic                start_o,
  output logic                abort_o,
  output logic [CHAN_W-1:0]   chan_o,
  output logic                pwr_o,
  output logic [DLY_W-1:0]    dly_o,
  output logic                irq_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]    reg_idx;
  logic                ctrl_wr;
  logic                pwr_req;
  logic [RES_BITS-1:0] result_q;
  logic                ie_q;
  logic                irq_st_q;

  assign reg_idx = addr_i[ADDR_W-1:2];
  assign ctrl_wr = we_i && (reg_idx == IDX_W'(REG_CTRL));
  assign pwr_req = wdata_i[CTRL_PWR_BIT];
  assign start_o = ctrl_wr && pwr_req && !busy_i;
  assign abort_o = ctrl_wr && !pwr_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_o   <= '0;
      pwr_o    <= 1'b0;
      ie_q     <= 1'b0;
      irq_st_q <= 1'b0;
      result_q <= '0;
      dly_o    <= DLY_W'(DLY_RST);
    end else begin
      if (start_o || abort_o) begin
        chan_o <= wdata_i[CHAN_W-1:0];
        pwr_o  <= pwr_req;
        ie_q   <= wdata_i[CTRL_IE_BIT];
      end
      if (abort_o) begin
        irq_st_q <= 1'b0;
      end else if (done_i) begin
        irq_st_q <= 1'b1;
        result_q <= result_i;
      end
      if (we_i && reg_idx == IDX_W'(REG_DELAY)) dly_o <= wdata_i[DLY_W-1:0];
    end
  end

  assign irq_o = irq_st_q && ie_q;

  always_comb begin
    rdata_o = '0;
    case (reg_idx)
      IDX_W'(REG_RESULT): rdata_o[RES_BITS-1:0] = result_q;
      IDX_W'(REG_STATUS): rdata_o[0] = busy_i;
      IDX_W'(REG_CTRL): begin
        rdata_o[CHAN_W-1:0]   = chan_o;
        rdata_o[CTRL_PWR_BIT] = pwr_o;
        rdata_o[CTRL_IE_BIT]  = ie_q;
        rdata_o[CTRL_IRQ_BIT] = irq_st_q;
      end
      IDX_W'(REG_DELAY): rdata_o[DLY_W-1:0] = dly_o;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl import sar_adc_pkg::*; #(
  parameter int unsigned RES_BITS = 10,
  parameter int unsigned CHAN_W   = 3,
  parameter int unsigned DLY_W    = 6,
  parameter int unsigned DLY_RST  = 8,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic                cmp_i,
  output logic                pwr_en_o,
  output logic [CHAN_W-1:0]   chan_sel_o,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic                irq_o
);
  logic                busy, conv, load, step, done, last;
  logic                start, abort;
  logic [DLY_W-1:0]    dly;
  logic [RES_BITS-1:0] result;

  sar_adc_regs #(
    .RES_BITS(RES_BITS), .CHAN_W(CHAN_W), .DLY_W(DLY_W),
    .DLY_RST(DLY_RST), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .busy_i(busy), .done_i(done),
    .result_i(result), .start_o(start), .abort_o(abort), .chan_o(chan_sel_o),
    .pwr_o(pwr_en_o), .dly_o(dly), .irq_o(irq_o)
  );

  sar_adc_seq #(.DLY_W(DLY_W)) seq_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .abort_i(abort),
    .dly_i(dly), .last_i(last), .busy_o(busy), .conv_o(conv),
    .load_o(load), .step_o(step), .done_o(done)
  );

  sar_adc_search #(.RES_BITS(RES_BITS)) search_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step),
    .conv_i(conv), .cmp_i(cmp_i), .trial_o(dac_code_o),
    .result_o(result), .last_o(last)
  );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int unsigned RES_BITS = 10,
  parameter int unsigned CHAN_W   = 3,
  parameter int unsigned ADDR_W   = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [31:0]         wdata_i,
  input logic                pwr_en_o,
  input logic [CHAN_W-1:0]   chan_sel_o,
  input logic [RES_BITS-1:0] dac_code_o,
  input logic                irq_o,
  input logic                busy_i
);
  logic ctrl_wr;
  assign ctrl_wr = we_i && (addr_i[ADDR_W-1:2] == 2);

  a_r3_busy_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> pwr_en_o);

  a_r4_dac_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> dac_code_o == '0);

  a_r8_chan_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && ctrl_wr && wdata_i[3]) |=> $stable(chan_sel_o));

  a_r9_power_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !wdata_i[3]) |=> (!busy_i && !pwr_en_o && !irq_o));

  a_r7_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(busy_i) || $past(ctrl_wr)));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(
  .RES_BITS(RES_BITS), .CHAN_W(CHAN_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .pwr_en_o(pwr_en_o), .chan_sel_o(chan_sel_o),
  .dac_code_o(dac_code_o), .irq_o(irq_o), .busy_i(busy)
);

// File: tb/sar_adc_ctrl_tb_top.sv
module sar_adc_ctrl_tb_top;
  localparam int RES = 10;
  localparam logic [3:0] A_RES = 4'h0, A_STAT = 4'h4, A_CTRL = 4'h8, A_DLY = 4'hC;

  typedef struct packed {
    logic [2:0]     chan;
    logic [5:0]     dly;
    logic [RES-1:0] tgt;
    logic           ie;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 6'd8,  10'd0,    1'b1},
    '{3'd7, 6'd0,  10'd1023, 1'b0},
    '{3'd3, 6'd1,  10'd512,  1'b1},
    '{3'd4, 6'd63, 10'd341,  1'b1},
    '{3'd6, 6'd5,  10'd682,  1'b0},
    '{3'd1, 6'd2,  10'd1,    1'b1}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           we = 1'b0;
  logic [3:0]     addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata;
  logic           cmp;
  logic           pwr_en;
  logic [2:0]     chan_sel;
  logic [RES-1:0] dac_code;
  logic           irq;
  logic [RES-1:0] tgt = '0;
  int             cyc = 0;
  int             n_chk = 0;
  int             n_err = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // ideal comparator
  assign cmp = (tgt >= dac_code);

  sar_adc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cmp_i(cmp), .pwr_en_o(pwr_en), .chan_sel_o(chan_sel),
    .dac_code_o(dac_code), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_idle(input int t0, output int dur);
    logic [31:0] s;
    rd(A_STAT, s);
    while (s[0]) begin
      @(negedge clk);
      rd(A_STAT, s);
    end
    dur = cyc - t0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int t0, dur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_RES, v);  check("R1 result", v, 0);
    rd(A_STAT, v); check("R1 status", v, 0);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_DLY, v);  check("R1 delay", v, 8);
    check("R1 pwr", pwr_en, 0);
    check("R1 irq", irq, 0);
    check("R1 dac", dac_code, 0);

    // R10 delay width
    wr(A_DLY, 32'hFFFF_FFFF);
    rd(A_DLY, v); check("R10 delay mask", v, 32'h3F);

    // table-driven conversions
    for (int i = 0; i < NV; i++) begin
      tgt = VECS[i].tgt;
      wr(A_DLY, 32'(VECS[i].dly));
      wr(A_CTRL, 32'(VECS[i].chan) | 32'h8 | (32'(VECS[i].ie) << 5));
      t0 = cyc;
      check("R3 chan_sel", 32'(chan_sel), 32'(VECS[i].chan));
      check("R3 pwr", pwr_en, 1);
      rd(A_STAT, v); check("R3 busy", v, 1);
      if (VECS[i].dly != 0) check("R4 dac quiet in delay", 32'(dac_code), 0);
      wait_idle(t0, dur);
      if (VECS[i].dly == 0) check("R11 zero-delay duration", dur, RES);
      else check("R4 busy duration", dur, 32'(VECS[i].dly) + RES);
      rd(A_RES, v);  check("R5 R2 result", v, 32'(VECS[i].tgt));
      rd(A_CTRL, v); check("R6 ctrl after done", v,
                           32'(VECS[i].chan) | 32'h48 | (32'(VECS[i].ie) << 5));
      check("R6 pwr stays", pwr_en, 1);
      check("R7 irq", irq, VECS[i].ie);
      wr(A_CTRL, 32'h0);
      check("R9 pwr off", pwr_en, 0);
      check("R9 irq off", irq, 0);
      rd(A_CTRL, v); check("R9 ctrl cleared", v, 0);
      rd(A_RES, v);  check("R9 result kept", v, 32'(VECS[i].tgt));
    end

    // R8 restart attempt during delay is ignored
    tgt = 10'd300;
    wr(A_DLY, 32'd8);
    wr(A_CTRL, 32'h2 | 32'h8);
    t0 = cyc;
    @(negedge clk); @(negedge clk);
    wr(A_CTRL, 32'h5 | 32'h8 | 32'h20);
    check("R8 chan_sel held", 32'(chan_sel), 2);
    wait_idle(t0, dur);
    check("R8 duration unchanged", dur, 8 + RES);
    rd(A_RES, v);  check("R8 result", v, 300);
    rd(A_CTRL, v); check("R8 ctrl fields", v, 32'h2 | 32'h48);
    check("R8 R7 irq stays low", irq, 0);
    wr(A_CTRL, 32'h0);

    // R9 abort in the middle of the search
    tgt = 10'd700;
    wr(A_DLY, 32'd4);
    wr(A_CTRL, 32'h1 | 32'h8 | 32'h20);
    repeat (7) @(negedge clk);
    rd(A_STAT, v); check("R9 still busy before abort", v, 1);
    wr(A_CTRL, 32'h0);
    rd(A_STAT, v); check("R9 busy cleared", v, 0);
    check("R9 pwr", pwr_en, 0);
    check("R9 dac idle", 32'(dac_code), 0);
    check("R9 irq", irq, 0);
    rd(A_RES, v);  check("R9 result retained", v, 300);
    repeat (15) @(negedge clk);
    rd(A_CTRL, v); check("R9 no late completion", v, 0);

    // R9 abort during the delay, then a clean zero-delay conversion
    wr(A_DLY, 32'd20);
    wr(A_CTRL, 32'h8);
    @(negedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_STAT, v); check("R9 abort in delay", v, 0);
    tgt = 10'd5;
    wr(A_DLY, 32'd0);
    wr(A_CTRL, 32'h3 | 32'h8 | 32'h20);
    t0 = cyc;
    wait_idle(t0, dur);
    check("R11 duration after abort", dur, RES);
    rd(A_RES, v); check("R5 result after abort", v, 5);
    check("R7 irq set", irq, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule